// File: doc/BRIEF.md
# Subtract-With-Borrow Register-File Datapath

This block carries out one instruction of an 8-bit accumulator core: subtract a data-memory operand and the pending borrow from the working register. It takes a 16-bit instruction word and recognises the subtract-with-borrow opcode. It builds a 12-bit data-memory address in one of two ways: from a fixed low/high split of the shared access window, or from the 4-bit bank pointer. It reads the operand through a synchronous register-file port and computes W − f − borrow, where the borrow is the complement of the incoming carry. The result goes either back to the working register or to the same file location, and the block also produces a new five-bit status word.

Each instruction passes through four phases, one clock each: decode, operand read, arithmetic and write-back. The working register, the carry and the bank pointer stay in the surrounding core. This block reads them as inputs and hands back write strobes with the new values. A new instruction can be taken in the write-back phase, so one instruction completes every four clocks.

Top module: `swb_exec`

## Requirements
- R1: Only an instruction whose bits [15:10] equal 6'b010101 is accepted; any other word causes no register-file read, no register-file write, no W write and no status write.
- R2: The result is (W − f − (1 − C)) modulo 256, where f is the operand read from the register file and C is the carry input sampled in the arithmetic phase.
- R3: With bit 8 (bank-select use) at 0, file address field f (bits [7:0]) below 8'h80 addresses 12'h000 + f, and f of 8'h80 or above addresses 12'hF00 + f; the bank pointer is ignored.
- R4: With bit 8 at 1, the address is {bank pointer, f}.
- R5: With bit 9 (destination) at 0 only W is written; with bit 9 at 1 only the register file is written, at the same address that was read.
- R6: Status bit 0 (carry) is 1 exactly when no borrow leaves bit 7, i.e. W ≥ f + (1 − C) unsigned; status bit 1 (digit carry) is the same test on bits [3:0].
- R7: Status bit 4 (negative) equals result bit 7, bit 2 (zero) is 1 when the result is 0, and bit 3 (overflow) is 1 when W and f differ in sign and the result sign differs from W's sign.
- R8: With the instruction accepted at clock edge E, the read strobe is high for the single cycle between E+1 and E+2. The W or file write strobe and the status strobe are high together for the single cycle between E+3 and E+4.
- R9: An instruction offered in the decode, read or arithmetic phase is ignored. One offered in the write-back phase is accepted, so back-to-back instructions run every four cycles and the second one sees the first one's W and carry.
- R10: While reset is high and after its release until an instruction is accepted, all strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_valid_i | input | 1 | Instruction word present this cycle |
| insn_i | input | 16 | Instruction word |
| w_i | input | 8 | Current working register |
| c_i | input | 1 | Current carry flag |
| bsr_i | input | 4 | Bank pointer |
| rf_rdata_i | input | 8 | Register-file read data, one cycle after the read strobe |
| rf_re_o | output | 1 | Register-file read strobe |
| rf_we_o | output | 1 | Register-file write strobe |
| rf_addr_o | output | 12 | Register-file address for read and write |
| rf_wdata_o | output | 8 | Register-file write data |
| w_we_o | output | 1 | Working-register write strobe |
| w_o | output | 8 | New working-register value |
| stat_we_o | output | 1 | Status write strobe |
| stat_o | output | 5 | New status {N, OV, Z, DC, C} |

## Verification
The bench builds the block with its default parameters: 8-bit data, a 4-bit bank pointer and the shared-window split at 8'h80. With these values the example operands with a result of 8'hFF, 3 and 0, and both signed-overflow directions, can be worked out by hand. Both halves of the shared window and the 12'hF80 special-register region are reached with single file addresses. Phase counts and back-to-back issue can be observed at the strobes within a few cycles.

// File: rtl/swb_pkg.sv
package swb_pkg;

    localparam int          SWB_OPC_W = 6;
    localparam logic [5:0]  SWB_OPC   = 6'b010101;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_DEC  = 3'd1,
        PH_RD   = 3'd2,
        PH_EXE  = 3'd3,
        PH_WB   = 3'd4
    } swb_phase_e;

    // Status word layout as seen by the rest of the core: bit4..bit0
    typedef struct packed {
        logic neg;
        logic ovf;
        logic zero;
        logic dcy;
        logic cy;
    } swb_flags_t;

    function automatic logic swb_opc_hit(input logic [SWB_OPC_W-1:0] opc);
        return opc == SWB_OPC;
    endfunction

endpackage

// File: rtl/swb_decode.sv
module swb_decode
    import swb_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int INSN_W = SWB_OPC_W + 2 + DATA_W
) (
    input  logic [INSN_W-1:0] insn_i,
    output logic              hit_o,
    output logic              to_file_o,
    output logic              use_bank_o,
    output logic [DATA_W-1:0] fld_f_o
);
    localparam int D_POS = DATA_W + 1;
    localparam int A_POS = DATA_W;

    always_comb begin
        hit_o      = swb_opc_hit(insn_i[INSN_W-1 -: SWB_OPC_W]);
        to_file_o  = insn_i[D_POS];
        use_bank_o = insn_i[A_POS];
        fld_f_o    = insn_i[DATA_W-1:0];
    end
endmodule

// File: rtl/swb_addr.sv
module swb_addr #(
    parameter int          DATA_W    = 8,
    parameter int          BANK_W    = 4,
    parameter logic [7:0]  ACC_SPLIT = 8'h80,
    localparam int         ADDR_W    = BANK_W + DATA_W
) (
    input  logic              use_bank_i,
    input  logic [BANK_W-1:0] bank_i,
    input  logic [DATA_W-1:0] f_i,
    output logic [ADDR_W-1:0] addr_o
);
    localparam logic [DATA_W-1:0] SPLIT = DATA_W'(ACC_SPLIT);

    logic [BANK_W-1:0] win_bank;

    always_comb begin
        win_bank = (f_i >= SPLIT) ? {BANK_W{1'b1}} : {BANK_W{1'b0}};
        addr_o   = use_bank_i ? {bank_i, f_i} : {win_bank, f_i};
    end
endmodule

// File: rtl/swb_alu.sv
module swb_alu
    import swb_pkg::*;
#(
    parameter int  DATA_W = 8,
    localparam int NIB_W  = DATA_W / 2,
    localparam int MSB    = DATA_W - 1
) (
    input  logic [DATA_W-1:0] w_i,
    input  logic [DATA_W-1:0] f_i,
    input  logic              c_i,
    output logic [DATA_W-1:0] res_o,
    output swb_flags_t        flags_o
);
    logic [DATA_W-1:0] bgen;   // bit borrows regardless of incoming borrow
    logic [DATA_W-1:0] bprop;  // bit passes an incoming borrow on
    logic [DATA_W-1:0] hsum;
    logic [DATA_W:0]   bchain;

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        assign bgen[i]  = ~w_i[i] & f_i[i];
        assign bprop[i] = ~(w_i[i] ^ f_i[i]);
        assign hsum[i]  = w_i[i] ^ f_i[i];
    end

    always_comb begin
        bchain[0] = ~c_i;
        for (int i = 0; i < DATA_W; i++) begin
            bchain[i+1] = bgen[i] | (bprop[i] & bchain[i]);
        end
        res_o         = hsum ^ bchain[DATA_W-1:0];
        flags_o.cy    = ~bchain[DATA_W];
        flags_o.dcy   = ~bchain[NIB_W];
        flags_o.neg   = res_o[MSB];
        flags_o.zero  = ~|res_o;
        flags_o.ovf   = (w_i[MSB] ^ f_i[MSB]) & (res_o[MSB] ^ w_i[MSB]);
    end
endmodule

// File: rtl/swb_seq.sv
module swb_seq
    import swb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    output logic       accept_o,
    output swb_phase_e phase_o
);
    swb_phase_e ph_q, ph_d;

    always_comb begin
        accept_o = start_i && (ph_q == PH_IDLE || ph_q == PH_WB);
        unique case (ph_q)
            PH_IDLE: ph_d = accept_o ? PH_DEC : PH_IDLE;
            PH_DEC:  ph_d = PH_RD;
            PH_RD:   ph_d = PH_EXE;
            PH_EXE:  ph_d = PH_WB;
            PH_WB:   ph_d = accept_o ? PH_DEC : PH_IDLE;
            default: ph_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) ph_q <= PH_IDLE;
        else     ph_q <= ph_d;
    end

    assign phase_o = ph_q;

    AST_BUSY_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
        (ph_q == PH_DEC || ph_q == PH_RD || ph_q == PH_EXE) |=> (ph_q != PH_DEC)); // R9

    AST_WB_TAKES_NEXT: assert property (@(posedge clk) disable iff (rst)
        (ph_q == PH_WB && start_i) |=> (ph_q == PH_DEC)); // R9
endmodule

// File: rtl/swb_exec.sv
module swb_exec
    import swb_pkg::*;
#(
    parameter int          DATA_W    = 8,
    parameter int          BANK_W    = 4,
    parameter logic [7:0]  ACC_SPLIT = 8'h80,
    localparam int         ADDR_W    = BANK_W + DATA_W,
    localparam int         INSN_W    = SWB_OPC_W + 2 + DATA_W,
    localparam int         FLAG_W    = $bits(swb_flags_t)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              insn_valid_i,
    input  logic [INSN_W-1:0] insn_i,
    input  logic [DATA_W-1:0] w_i,
    input  logic              c_i,
    input  logic [BANK_W-1:0] bsr_i,
    input  logic [DATA_W-1:0] rf_rdata_i,
    output logic              rf_re_o,
    output logic              rf_we_o,
    output logic [ADDR_W-1:0] rf_addr_o,
    output logic [DATA_W-1:0] rf_wdata_o,
    output logic              w_we_o,
    output logic [DATA_W-1:0] w_o,
    output logic              stat_we_o,
    output logic [FLAG_W-1:0] stat_o
);
    // ---------------- decode of the incoming word ----------------
    logic              dec_hit, dec_to_file, dec_use_bank;
    logic [DATA_W-1:0] dec_f;

    swb_decode #(.DATA_W(DATA_W)) u_dec (
        .insn_i     (insn_i),
        .hit_o      (dec_hit),
        .to_file_o  (dec_to_file),
        .use_bank_o (dec_use_bank),
        .fld_f_o    (dec_f)
    );

    // ---------------- phase sequencer ----------------
    logic       accept;
    swb_phase_e phase;

    swb_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .start_i  (insn_valid_i && dec_hit),
        .accept_o (accept),
        .phase_o  (phase)
    );

    // ---------------- latched instruction fields ----------------
    logic              to_file_q, use_bank_q;
    logic [DATA_W-1:0] f_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            to_file_q  <= 1'b0;
            use_bank_q <= 1'b0;
            f_q        <= '0;
        end else if (accept) begin
            to_file_q  <= dec_to_file;
            use_bank_q <= dec_use_bank;
            f_q        <= dec_f;
        end
    end

    // ---------------- address formation in the decode phase ----------------
    logic [ADDR_W-1:0] addr_d, addr_q;

    swb_addr #(.DATA_W(DATA_W), .BANK_W(BANK_W), .ACC_SPLIT(ACC_SPLIT)) u_addr (
        .use_bank_i (use_bank_q),
        .bank_i     (bsr_i),
        .f_i        (f_q),
        .addr_o     (addr_d)
    );

    always_ff @(posedge clk) begin
        if (rst)                  addr_q <= '0;
        else if (phase == PH_DEC) addr_q <= addr_d;
    end

    // ---------------- arithmetic in the process phase ----------------
    logic [DATA_W-1:0] alu_res, res_q;
    swb_flags_t        alu_flags, flags_q;

    swb_alu #(.DATA_W(DATA_W)) u_alu (
        .w_i     (w_i),
        .f_i     (rf_rdata_i),
        .c_i     (c_i),
        .res_o   (alu_res),
        .flags_o (alu_flags)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q   <= '0;
            flags_q <= '0;
        end else if (phase == PH_EXE) begin
            res_q   <= alu_res;
            flags_q <= alu_flags;
        end
    end

    // ---------------- port drive ----------------
    always_comb begin
        rf_re_o    = (phase == PH_RD);
        rf_we_o    = (phase == PH_WB) &&  to_file_q;
        w_we_o     = (phase == PH_WB) && !to_file_q;
        stat_we_o  = (phase == PH_WB);
        rf_addr_o  = addr_q;
        rf_wdata_o = res_q;
        w_o        = res_q;
        stat_o     = flags_q;
    end

    // ---------------- checks ----------------
    AST_FOREIGN_OPC_IDLE: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE && insn_valid_i && !dec_hit) |=> (phase == PH_IDLE)); // R1

    AST_SINGLE_DEST: assert property (@(posedge clk) disable iff (rst)
        !(rf_we_o && w_we_o)); // R5

    AST_READ_LEADS_WRITE: assert property (@(posedge clk) disable iff (rst)
        (rf_we_o || w_we_o) |-> $past(rf_re_o, 2)); // R8

    AST_STATUS_WITH_RESULT: assert property (@(posedge clk) disable iff (rst)
        stat_we_o |-> (rf_we_o || w_we_o)); // R8

    AST_NEG_IS_MSB: assert property (@(posedge clk) disable iff (rst)
        stat_we_o |-> (stat_o[FLAG_W-1] == w_o[DATA_W-1])); // R7

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
        rf_we_o |-> $stable(rf_addr_o)); // R5
endmodule

// File: tb/tb_swb_exec.sv
`timescale 1ns/1ps
module tb_swb_exec;

    logic        clk = 1'b0;
    logic        rst;
    logic        insn_valid_i;
    logic [15:0] insn_i;
    logic [7:0]  w_reg;
    logic        c_reg;
    logic [3:0]  bsr;
    logic [7:0]  rf_rdata;
    logic        rf_re_o, rf_we_o, w_we_o, stat_we_o;
    logic [11:0] rf_addr_o;
    logic [7:0]  rf_wdata_o, w_o;
    logic [4:0]  stat_o;

    swb_exec dut (
        .clk(clk), .rst(rst),
        .insn_valid_i(insn_valid_i), .insn_i(insn_i),
        .w_i(w_reg), .c_i(c_reg), .bsr_i(bsr),
        .rf_rdata_i(rf_rdata),
        .rf_re_o(rf_re_o), .rf_we_o(rf_we_o), .rf_addr_o(rf_addr_o),
        .rf_wdata_o(rf_wdata_o), .w_we_o(w_we_o), .w_o(w_o),
        .stat_we_o(stat_we_o), .stat_o(stat_o)
    );

    always #4 clk = ~clk;   // 125 MHz

    int   total = 0;
    int   bad   = 0;
    logic finished = 1'b0;

    // register-file model: one operand value, synchronous read
    logic [7:0] file_val;
    always @(posedge clk) if (rf_re_o) rf_rdata <= file_val;

    // strobe monitor, sampled mid-cycle
    int          nc = 0;
    int          re_cnt, we_cnt, ww_cnt, sw_cnt;
    int          re_nc, we_nc, ww_nc, sw_nc;
    logic [11:0] re_addr, we_addr;
    logic [7:0]  we_data;
    logic [4:0]  stat_reg;

    always @(negedge clk) begin
        nc = nc + 1;
        if (rf_re_o)   begin re_cnt++; re_nc = nc; re_addr = rf_addr_o; end
        if (rf_we_o)   begin we_cnt++; we_nc = nc; we_addr = rf_addr_o; we_data = rf_wdata_o; end
        if (w_we_o)    begin ww_cnt++; ww_nc = nc; w_reg = w_o; end
        if (stat_we_o) begin sw_cnt++; sw_nc = nc; stat_reg = stat_o; c_reg = stat_o[0]; end
    end

    task automatic check(input logic ok, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic clear_mon();
        re_cnt = 0; we_cnt = 0; ww_cnt = 0; sw_cnt = 0;
        re_nc = -1; we_nc = -1; ww_nc = -1; sw_nc = -1;
    endtask

    // expected-value model straight from the requirements
    function automatic logic [12:0] model(input logic [7:0] w, input logic [7:0] f, input logic c);
        int         full, low;
        logic [7:0] r;
        logic [4:0] fl;
        full  = int'(w) - int'(f) - (c ? 0 : 1);
        low   = int'(w[3:0]) - int'(f[3:0]) - (c ? 0 : 1);
        r     = full[7:0];
        fl[0] = (full >= 0);
        fl[1] = (low  >= 0);
        fl[2] = (r == 8'h00);
        fl[3] = (w[7] != f[7]) && (r[7] != w[7]);
        fl[4] = r[7];
        return {fl, r};
    endfunction

    function automatic logic [11:0] exp_addr(input logic a, input logic [3:0] b, input logic [7:0] f);
        if (a) return {b, f};
        return (f >= 8'h80) ? {4'hF, f} : {4'h0, f};
    endfunction

    // issue one subtract and check every visible effect
    task automatic run_sub(input string tag, input logic d, input logic a, input logic [7:0] f,
                           input logic [7:0] w, input logic c, input logic [3:0] b,
                           input logic [7:0] fv);
        int          t0;
        logic [12:0] m;
        logic [11:0] ea;
        @(negedge clk); #1;
        clear_mon();
        w_reg = w; c_reg = c; bsr = b; file_val = fv;
        insn_i = {6'b010101, d, a, f};
        insn_valid_i = 1'b1;
        t0 = nc;
        @(negedge clk); #1;
        insn_valid_i = 1'b0;
        repeat (4) @(negedge clk);
        #1;
        m  = model(w, fv, c);
        ea = exp_addr(a, b, f);
        check(re_cnt == 1 && re_addr == ea, {tag, " R3/R4 read address"}, int'(re_addr), int'(ea));
        check(re_nc == t0 + 2, {tag, " R8 read cycle"}, re_nc - t0, 2);
        check(sw_nc == t0 + 4 && sw_cnt == 1, {tag, " R8 status cycle"}, sw_nc - t0, 4);
        if (d) begin
            check(we_cnt == 1 && ww_cnt == 0, {tag, " R5 file only"}, we_cnt * 16 + ww_cnt, 16);
            check(we_addr == ea, {tag, " R5 write address"}, int'(we_addr), int'(ea));
            check(we_data == m[7:0], {tag, " R2 file result"}, int'(we_data), int'(m[7:0]));
            check(we_nc == t0 + 4, {tag, " R8 write cycle"}, we_nc - t0, 4);
        end else begin
            check(ww_cnt == 1 && we_cnt == 0, {tag, " R5 W only"}, ww_cnt * 16 + we_cnt, 16);
            check(w_reg == m[7:0], {tag, " R2 W result"}, int'(w_reg), int'(m[7:0]));
            check(ww_nc == t0 + 4, {tag, " R8 write cycle"}, ww_nc - t0, 4);
        end
        check(stat_reg[1:0] == m[9:8], {tag, " R6 C/DC"}, int'(stat_reg[1:0]), int'(m[9:8]));
        check(stat_reg[4:2] == m[12:10], {tag, " R7 N/OV/Z"}, int'(stat_reg[4:2]), int'(m[12:10]));
    endtask

    task automatic t_reset();
        logic seen;
        seen = 1'b0;
        rst = 1'b1; insn_valid_i = 1'b0; insn_i = '0;
        w_reg = '0; c_reg = 1'b0; bsr = '0; file_val = '0; rf_rdata = '0;
        clear_mon();
        repeat (3) begin
            @(negedge clk);
            if (rf_re_o || rf_we_o || w_we_o || stat_we_o) seen = 1'b1;
        end
        rst = 1'b0;
        repeat (3) begin
            @(negedge clk);
            if (rf_re_o || rf_we_o || w_we_o || stat_we_o) seen = 1'b1;
        end
        check(!seen, "R10 strobes low in and after reset", int'(seen), 0);
    endtask

    task automatic t_examples();
        // W=2 f=3 C=1 -> FF, C=0 N=1
        run_sub("ex1", 1'b1, 1'b0, 8'h20, 8'h02, 1'b1, 4'h0, 8'h03);
        check(we_data == 8'hFF && stat_reg[0] == 1'b0 && stat_reg[4] == 1'b1,
              "R2 R6 R7 ex1 literal", int'(we_data), 8'hFF);
        // W=5 f=2 C=1 -> 3 into W
        run_sub("ex2", 1'b0, 1'b0, 8'h21, 8'h05, 1'b1, 4'h0, 8'h02);
        check(w_reg == 8'h03 && stat_reg == 5'b00011, "R2 R6 ex2 literal", int'(stat_reg), 5'b00011);
        // W=2 f=1 C=0 -> 0, Z=1 C=1
        run_sub("ex3", 1'b1, 1'b0, 8'h22, 8'h02, 1'b0, 4'h0, 8'h01);
        check(we_data == 8'h00 && stat_reg == 5'b00111, "R6 R7 ex3 zero", int'(stat_reg), 5'b00111);
    endtask

    task automatic t_overflow();
        // positive result from negative minuend: 80 - 01 = 7F, OV=1, DC=0
        run_sub("ovA", 1'b0, 1'b0, 8'h30, 8'h80, 1'b1, 4'h0, 8'h01);
        check(stat_reg == 5'b01001, "R7 overflow neg-pos", int'(stat_reg), 5'b01001);
        // 7F - FF = 80 with borrow, OV=1 N=1 DC=1
        run_sub("ovB", 1'b0, 1'b0, 8'h31, 8'h7F, 1'b1, 4'h0, 8'hFF);
        check(stat_reg == 5'b11010, "R7 overflow pos-neg", int'(stat_reg), 5'b11010);
        // borrow in with equal operands: 00 - 00 - 1 = FF
        run_sub("brw", 1'b1, 1'b0, 8'h32, 8'h00, 1'b0, 4'h0, 8'h00);
    endtask

    task automatic t_access();
        run_sub("accLo", 1'b1, 1'b0, 8'h7F, 8'h10, 1'b1, 4'h9, 8'h04);   // R3 low half, bank ignored
        run_sub("accHi", 1'b1, 1'b0, 8'h80, 8'h10, 1'b1, 4'h9, 8'h04);   // R3 high half
        run_sub("accTop", 1'b0, 1'b0, 8'hFF, 8'h33, 1'b0, 4'h2, 8'h11);  // R3
    endtask

    task automatic t_bank();
        run_sub("bnk5", 1'b1, 1'b1, 8'h44, 8'hA0, 1'b1, 4'h5, 8'h0F);    // R4
        run_sub("bnkF", 1'b0, 1'b1, 8'h01, 8'h09, 1'b0, 4'hF, 8'h09);    // R4
        run_sub("bnk0", 1'b1, 1'b1, 8'hC0, 8'h55, 1'b1, 4'h0, 8'hAA);    // R4
    endtask

    task automatic t_foreign();
        @(negedge clk); #1;
        clear_mon();
        insn_i = 16'h5E10;   // bits[15:10] = 010111
        insn_valid_i = 1'b1;
        @(negedge clk); #1;
        insn_i = 16'h0000;
        @(negedge clk); #1;
        insn_valid_i = 1'b0;
        repeat (6) @(negedge clk);
        #1;
        check(re_cnt + we_cnt + ww_cnt + sw_cnt == 0, "R1 other opcodes idle",
              re_cnt + we_cnt + ww_cnt + sw_cnt, 0);
    endtask

    task automatic t_busy();
        int t0;
        @(negedge clk); #1;
        clear_mon();
        w_reg = 8'h40; c_reg = 1'b1; bsr = 4'h0; file_val = 8'h10;
        insn_i = {6'b010101, 1'b1, 1'b0, 8'h05};
        insn_valid_i = 1'b1;
        t0 = nc;
        @(negedge clk); #1;
        insn_i = {6'b010101, 1'b0, 1'b0, 8'h06};  // offered during decode/read/process
        repeat (3) @(negedge clk);
        #1;
        insn_valid_i = 1'b0;
        repeat (4) @(negedge clk);
        #1;
        check(re_cnt == 1 && ww_cnt == 0, "R9 busy offer ignored", re_cnt * 16 + ww_cnt, 16);
        check(we_data == 8'h30 && we_addr == 12'h005, "R9 first op intact", int'(we_data), 8'h30);
    endtask

    task automatic t_b2b();
        int t0;
        @(negedge clk); #1;
        clear_mon();
        w_reg = 8'h02; c_reg = 1'b1; bsr = 4'h0; file_val = 8'h03;
        insn_i = {6'b010101, 1'b0, 1'b0, 8'h11};  // to W: 02-03 = FF, C=0
        insn_valid_i = 1'b1;
        t0 = nc;
        @(negedge clk); #1;
        insn_valid_i = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        file_val = 8'h01;                         // operand of the second op
        insn_i = {6'b010101, 1'b1, 1'b0, 8'h12};  // offered in write-back phase
        insn_valid_i = 1'b1;
        @(negedge clk); #1;
        insn_valid_i = 1'b0;
        repeat (5) @(negedge clk);
        #1;
        check(re_cnt == 2 && re_nc == t0 + 6, "R9 second read four cycles later", re_nc - t0, 6);
        // second op: FF - 01 - 1 = FD, no borrow
        check(we_data == 8'hFD && we_nc == t0 + 8, "R9 chained W and carry", int'(we_data), 8'hFD);
        check(stat_reg[0] == 1'b1, "R6 chained carry out", int'(stat_reg[0]), 1);
    endtask

    initial begin
        t_reset();
        t_examples();
        t_overflow();
        t_access();
        t_bank();
        t_foreign();
        t_busy();
        t_b2b();
        repeat (2) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule